// File: doc/BRIEF.md
# Filtered Performance Event Counter

This block is one programmable performance-monitoring counter. Each clock cycle it receives, for each of several hardware threads, the number of times a monitored event occurred in that cycle. It also receives a thread-activity vector and the current privilege level. From these it forms the cycle's occurrence total. That total is either the owning thread's count alone or the sum over every active thread. The total then passes a privilege filter, a threshold compare, an optional invert and an optional rising-edge detector, and the result is added to a wide wrapping counter.

Software programs the counter through a 16-bit configuration register, which it can read back. It also reads the counter value and can overwrite the counter directly. A sticky flag records wrap-around. A second flag reports the one configuration that cannot be used: edge detection with a zero threshold. The counter is meant to sit beside a core, with the event source already selected upstream.

Top module: `perf_evt_counter`

## Requirements
- R1: After synchronous reset the counter reads 0, the overflow flag is 0, the configuration reads 0 and the illegal flag is 0.
- R2: A configuration write stores the field layout enable bit 0, user bit 1, kernel bit 2, invert bit 3, edge bit 4, any-thread bit 5 and threshold bits 15:8. Bits 7:6 read back as 0. The readback shows the new value from the cycle after the write.
- R3: With privilege level 0 a cycle can count only if the kernel bit is set. With levels 1 to 3 it can count only if the user bit is set. A cycle that fails this filter adds nothing, even with invert set.
- R4: With any-thread clear, the occurrence total is the owning thread's count if that thread is active and 0 otherwise. With any-thread set, it is the sum of the counts of all active threads. Thread t's count sits in bits 4t+3:4t of the count input.
- R5: With threshold 0 and invert clear, each cycle that passes the privilege filter adds its occurrence total to the counter.
- R6: With a nonzero threshold, a cycle adds exactly 1 when its total is greater than or equal to the threshold, and adds 0 otherwise.
- R7: With invert set, a cycle adds 1 when the threshold condition fails, and adds 0 when it holds. With threshold 0, this means a cycle adds 1 when its total is 0.
- R8: With edge set and a nonzero threshold, the counter adds 1 only on a qualifying cycle whose preceding cycle did not qualify.
- R9: Edge set with threshold 0 raises the illegal flag, and while it is set the counter does not count.
- R10: The counter is 48 bits and wraps modulo 2^48. A wrap sets the overflow flag, which stays set until the next counter write clears it.
- R11: A counter write in the same cycle as a counting event loads the written value and discards the increment.
- R12: While the enable bit is 0 the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Configuration readback |
| cfg_illegal | output | 1 | Edge mode with zero threshold |
| ctr_we | input | 1 | Counter write strobe |
| ctr_wdata | input | 48 | Counter write data |
| ctr_value | output | 48 | Counter value |
| ctr_ovf | output | 1 | Sticky wrap flag |
| evt_cnt | input | 16 | Per-thread occurrence counts, 4 bits per thread |
| thread_act | input | 4 | Thread-activity vector |
| priv_lvl | input | 2 | Current privilege level |

## Verification
The state that is hardest to reach from the ports is the edge detector's memory of the previous cycle. This memory is invisible at the ports and can only be inferred from how much the counter grows over a run of cycles. The bench first passes through the illegal configuration, which keeps the detector cleared. It then drives a set sequence of below-threshold and above-threshold cycles and checks the counter part-way through and at the end. Wrap-around is reached quickly by loading the counter with a value two below 2^48 before adding a burst.

// File: rtl/pec_pkg.sv
package pec_pkg;
  localparam int CFG_W = 16;

  typedef struct packed {
    logic [7:0] thr;
    logic [1:0] pad;
    logic       any;
    logic       edg;
    logic       inv;
    logic       krn;
    logic       usr;
    logic       en;
  } pec_cfg_t;
endpackage

// File: rtl/pec_thread_sel.sv
module pec_thread_sel #(
  parameter int NUM_THREADS = 4,
  parameter int OCC_W       = 4,
  parameter int OWN_THREAD  = 0,
  localparam int SUM_W      = OCC_W + $clog2(NUM_THREADS + 1)
) (
  input  logic [NUM_THREADS*OCC_W-1:0] evt_cnt,
  input  logic [NUM_THREADS-1:0]       thread_act,
  input  logic                         any_thread,
  output logic [SUM_W-1:0]             occ
);
  logic [SUM_W-1:0] part [NUM_THREADS+1];

  assign part[0] = '0;
  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_sum
    logic [SUM_W-1:0] term;
    assign term = thread_act[t] ? SUM_W'(evt_cnt[t*OCC_W +: OCC_W]) : '0;
    assign part[t+1] = part[t] + term;
  end

  logic [SUM_W-1:0] own_occ;
  assign own_occ = thread_act[OWN_THREAD] ?
                   SUM_W'(evt_cnt[OWN_THREAD*OCC_W +: OCC_W]) : '0;

  assign occ = any_thread ? part[NUM_THREADS] : own_occ;
endmodule

// File: rtl/pec_qualify.sv
module pec_qualify
  import pec_pkg::*;
#(
  parameter int SUM_W  = 7,
  parameter int PRIV_W = 2,
  localparam int CMP_W = (SUM_W > 8) ? SUM_W : 8
) (
  input  logic              clk,
  input  logic              rst,
  input  pec_cfg_t          cfg,
  input  logic [PRIV_W-1:0] priv_lvl,
  input  logic [SUM_W-1:0]  occ,
  output logic              active,
  output logic              illegal,
  output logic [SUM_W-1:0]  inc
);
  logic             priv_ok, meets, cond, prev_q;
  logic [CMP_W-1:0] occ_x, thr_x;

  assign occ_x   = CMP_W'(occ);
  assign thr_x   = CMP_W'(cfg.thr);
  assign priv_ok = (priv_lvl == '0) ? cfg.krn : cfg.usr;
  assign meets   = (cfg.thr == 8'd0) ? (occ_x != '0) : (occ_x >= thr_x);
  assign cond    = priv_ok && (cfg.inv ? !meets : meets);
  assign illegal = cfg.edg && (cfg.thr == 8'd0);
  assign active  = cfg.en && !illegal;

  always_comb begin
    inc = '0;
    if (active) begin
      if (cfg.edg)
        inc = (cond && !prev_q) ? SUM_W'(1) : '0;
      else if (cfg.thr == 8'd0 && !cfg.inv)
        inc = priv_ok ? occ : '0;
      else
        inc = cond ? SUM_W'(1) : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !active) prev_q <= 1'b0;
    else                prev_q <= cond;
  end

  // R8: an edge count can never be followed directly by another
  a_r8_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
    (cfg.edg && inc != '0) |=> (!(cfg.edg && $stable(cfg)) || inc == '0));

  // R6: with a threshold, a cycle adds at most one
  a_r6_unit_step: assert property (@(posedge clk) disable iff (rst)
    (cfg.thr != 8'd0) |-> (inc <= SUM_W'(1)));
endmodule

// File: rtl/pec_accum.sv
module pec_accum #(
  parameter int CTR_W = 48,
  parameter int SUM_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             count_en,
  input  logic [SUM_W-1:0] inc,
  input  logic             wr_en,
  input  logic [CTR_W-1:0] wr_data,
  output logic [CTR_W-1:0] value,
  output logic             ovf
);
  logic [CTR_W:0] sum;
  assign sum = {1'b0, value} + (CTR_W+1)'(inc);

  always_ff @(posedge clk) begin
    if (rst) begin
      value <= '0;
      ovf   <= 1'b0;
    end else if (wr_en) begin
      value <= wr_data;
      ovf   <= 1'b0;
    end else if (count_en) begin
      value <= sum[CTR_W-1:0];
      if (sum[CTR_W]) ovf <= 1'b1;
    end
  end

  a_r11_write_wins: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (value == $past(wr_data)));

  a_r10_write_clears_ovf: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !ovf);

  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf && !wr_en) |=> ovf);

  a_r12_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    (!count_en && !wr_en) |=> $stable(value));
endmodule

// File: rtl/perf_evt_counter.sv
module perf_evt_counter
  import pec_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int OCC_W       = 4,
  parameter int OWN_THREAD  = 0,
  parameter int CTR_W       = 48,
  parameter int PRIV_W      = 2,
  localparam int SUM_W      = OCC_W + $clog2(NUM_THREADS + 1)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cfg_we,
  input  logic [CFG_W-1:0]             cfg_wdata,
  output logic [CFG_W-1:0]             cfg_rdata,
  output logic                         cfg_illegal,
  input  logic                         ctr_we,
  input  logic [CTR_W-1:0]             ctr_wdata,
  output logic [CTR_W-1:0]             ctr_value,
  output logic                         ctr_ovf,
  input  logic [NUM_THREADS*OCC_W-1:0] evt_cnt,
  input  logic [NUM_THREADS-1:0]       thread_act,
  input  logic [PRIV_W-1:0]            priv_lvl
);
  pec_cfg_t         cfg_q;
  logic [SUM_W-1:0] occ, inc;
  logic             active;

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= '0;
    else if (cfg_we) begin
      cfg_q     <= pec_cfg_t'(cfg_wdata);
      cfg_q.pad <= 2'b00;
    end
  end
  assign cfg_rdata = cfg_q;

  pec_thread_sel #(
    .NUM_THREADS(NUM_THREADS), .OCC_W(OCC_W), .OWN_THREAD(OWN_THREAD)
  ) sel_i (
    .evt_cnt(evt_cnt), .thread_act(thread_act),
    .any_thread(cfg_q.any), .occ(occ)
  );

  pec_qualify #(.SUM_W(SUM_W), .PRIV_W(PRIV_W)) qual_i (
    .clk(clk), .rst(rst), .cfg(cfg_q), .priv_lvl(priv_lvl), .occ(occ),
    .active(active), .illegal(cfg_illegal), .inc(inc)
  );

  pec_accum #(.CTR_W(CTR_W), .SUM_W(SUM_W)) acc_i (
    .clk(clk), .rst(rst), .count_en(active), .inc(inc),
    .wr_en(ctr_we), .wr_data(ctr_wdata), .value(ctr_value), .ovf(ctr_ovf)
  );

  // R9: an illegal configuration never advances the counter
  a_r9_illegal_frozen: assert property (@(posedge clk) disable iff (rst)
    (cfg_illegal && !ctr_we) |=> $stable(ctr_value));

  // R2: pad bits never read back as one
  a_r2_pad_zero: assert property (@(posedge clk) disable iff (rst)
    cfg_rdata[7:6] == 2'b00);
endmodule

// File: tb/perf_evt_counter_tb_top.sv
module perf_evt_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        cfg_illegal;
  logic        ctr_we = 1'b0;
  logic [47:0] ctr_wdata = '0;
  logic [47:0] ctr_value;
  logic        ctr_ovf;
  logic [15:0] evt_cnt = '0;
  logic [3:0]  thread_act = '0;
  logic [1:0]  priv_lvl = 2'd3;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  perf_evt_counter dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .cfg_illegal(cfg_illegal), .ctr_we(ctr_we),
    .ctr_wdata(ctr_wdata), .ctr_value(ctr_value), .ctr_ovf(ctr_ovf),
    .evt_cnt(evt_cnt), .thread_act(thread_act), .priv_lvl(priv_lvl)
  );

  typedef struct packed {
    logic [15:0] cfg;
    logic [1:0]  priv;
    logic [3:0]  act;
    logic [15:0] cnt;
    logic [7:0]  exp;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{16'h0007, 2'd3, 4'hF, 16'h0005, 8'd5},   // R5 raw add
    '{16'h0027, 2'd3, 4'hF, 16'h1235, 8'd11},  // R4 all threads
    '{16'h0027, 2'd3, 4'h5, 16'h1235, 8'd7},   // R4 active subset
    '{16'h0007, 2'd3, 4'hE, 16'h0005, 8'd0},   // R4 owner inactive
    '{16'h0003, 2'd0, 4'hF, 16'h0004, 8'd0},   // R3 user only, level 0
    '{16'h0005, 2'd0, 4'hF, 16'h0004, 8'd4},   // R3 kernel only, level 0
    '{16'h0003, 2'd2, 4'hF, 16'h0004, 8'd4},   // R3 user only, level 2
    '{16'h0005, 2'd1, 4'hF, 16'h0004, 8'd0},   // R3 kernel only, level 1
    '{16'h0307, 2'd3, 4'hF, 16'h0003, 8'd1},   // R6 equal threshold
    '{16'h0307, 2'd3, 4'hF, 16'h0002, 8'd0},   // R6 below threshold
    '{16'h030F, 2'd3, 4'hF, 16'h0002, 8'd1},   // R7 inverted below
    '{16'h030F, 2'd3, 4'hF, 16'h0005, 8'd0},   // R7 inverted above
    '{16'h000F, 2'd3, 4'hF, 16'h0000, 8'd1},   // R7 zero threshold
    '{16'h0006, 2'd3, 4'hF, 16'h0005, 8'd0},   // R12 disabled
    '{16'hFF27, 2'd3, 4'hF, 16'hFFFF, 8'd0},   // R6 threshold 255
    '{16'h3C27, 2'd3, 4'hF, 16'hFFFF, 8'd1},   // R6 threshold 60
    '{16'h030B, 2'd0, 4'hF, 16'h0000, 8'd0}    // R3 filter beats invert
  };

  function automatic string tag_of(int i);
    case (i)
      0:                 return "R5";
      1, 2, 3:           return "R4";
      4, 5, 6, 7, 16:    return "R3";
      8, 9, 14, 15:      return "R6";
      10, 11, 12:        return "R7";
      default:           return "R12";
    endcase
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    thread_act = '0;
    evt_cnt    = '0;
    priv_lvl   = 2'd3;
  endtask

  task automatic write_cfg(logic [15:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic write_ctr(logic [47:0] v);
    @(negedge clk); ctr_we = 1'b1; ctr_wdata = v;
    @(negedge clk); ctr_we = 1'b0;
  endtask

  task automatic drive(logic [3:0] a, logic [15:0] c, logic [1:0] p);
    thread_act = a; evt_cnt = c; priv_lvl = p;
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures",
               n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 counter", 64'(ctr_value), 64'd0);
    check("R1 ovf", 64'(ctr_ovf), 64'd0);
    check("R1 cfg", 64'(cfg_rdata), 64'd0);
    check("R1 illegal", 64'(cfg_illegal), 64'd0);

    // R2 readback with pad bits masked
    write_cfg(16'hABC0);
    check("R2 readback", 64'(cfg_rdata), 64'hAB00);
    write_cfg(16'h5A3F);
    check("R2 readback", 64'(cfg_rdata), 64'h5A3F);

    // vector table
    for (int i = 0; i < NV; i++) begin
      write_cfg(VECS[i].cfg);
      write_ctr(48'd0);
      drive(VECS[i].act, VECS[i].cnt, VECS[i].priv);
      check(tag_of(i), 64'(ctr_value), 64'(VECS[i].exp));
      idle();
    end

    // R9 illegal configuration
    write_cfg(16'h0017);
    check("R9 flag", 64'(cfg_illegal), 64'd1);
    write_ctr(48'd0);
    drive(4'hF, 16'h0005, 2'd3);
    drive(4'hF, 16'h0000, 2'd3);
    drive(4'hF, 16'h0005, 2'd3);
    check("R9 no count", 64'(ctr_value), 64'd0);
    idle();

    // R8 edge detect, threshold 2
    write_cfg(16'h0217);
    check("R9 flag clear", 64'(cfg_illegal), 64'd0);
    write_ctr(48'd0);
    drive(4'hF, 16'h0000, 2'd3);
    drive(4'hF, 16'h0003, 2'd3);
    drive(4'hF, 16'h0003, 2'd3);
    check("R8 first edge", 64'(ctr_value), 64'd1);
    drive(4'hF, 16'h0001, 2'd3);
    drive(4'hF, 16'h0002, 2'd3);
    drive(4'hF, 16'h0002, 2'd3);
    idle();
    @(negedge clk);
    check("R8 second edge", 64'(ctr_value), 64'd2);

    // R10 wrap and sticky overflow
    write_cfg(16'h0007);
    write_ctr(48'hFFFF_FFFF_FFFE);
    check("R10 no ovf yet", 64'(ctr_ovf), 64'd0);
    drive(4'hF, 16'h0005, 2'd3);
    idle();
    check("R10 wrap value", 64'(ctr_value), 64'd3);
    check("R10 ovf set", 64'(ctr_ovf), 64'd1);
    @(negedge clk);
    check("R10 ovf sticky", 64'(ctr_ovf), 64'd1);
    write_ctr(48'h10);
    check("R10 ovf cleared", 64'(ctr_ovf), 64'd0);
    check("R10 written", 64'(ctr_value), 64'h10);

    // R11 write beats increment
    @(negedge clk);
    ctr_we = 1'b1; ctr_wdata = 48'h100;
    thread_act = 4'hF; evt_cnt = 16'h0005;
    @(negedge clk);
    ctr_we = 1'b0; idle();
    check("R11 write wins", 64'(ctr_value), 64'h100);

    // R12 disabled counter holds a nonzero value
    write_cfg(16'h0006);
    drive(4'hF, 16'h0005, 2'd3);
    drive(4'hF, 16'h0007, 2'd0);
    idle();
    check("R12 hold", 64'(ctr_value), 64'h100);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures",
             n_checks, n_fail);
    $finish;
  end
endmodule